// File: doc/BRIEF.md
# Multi-Context Register Frame File

This block keeps four hardware thread contexts resident at once. Each context owns a frame of 32 general registers of 32 bits and a saved fetch address. A frame pointer selects the live context. Two read ports and one write port take a 5-bit register index, and the physical address inside the shared storage is `{cur_ctx, index}`. Changing context therefore means changing the pointer. No register contents move.

When the pipeline hits a cache miss or a synchronization fault, it pulses `sw_req` and supplies the PC of the faulting instruction. On the next clock edge the block does three things:

- It stores that PC in the outgoing context's slot.
- It moves the pointer to the next context whose ready flag is set.
- It presents that context's saved PC on `fetch_pc`, with a one-cycle valid pulse.

If no other context is ready, the pointer stays where it is and `stall` is raised. The block resumes as soon as any ready flag rises. If the stall lasts long enough, `ldr_req` asks system software to swap a non-resident context in. Software uses the PC load port to write a context's saved PC.

Top module: `ctx_frame_rf`

## Requirements
- R1: While `rst` is high at a clock edge, the following outputs are 0 after that edge: `cur_ctx`, `fetch_pc`, `fetch_pc_vld`, `stall` and `ldr_req`. Every saved PC slot is also cleared to 0.
- R2: When `wr_en` is high, `wr_data` is written at the clock edge into register `wr_idx` of the frame named by `cur_ctx`. Frames are independent of one another, because the physical address is `{cur_ctx, wr_idx}`.
- R3: Reads are registered. `rd_data_a` and `rd_data_b` show, one edge after the indices are presented, the register contents of the frame that is current at that edge. A read of the address being written at the same edge returns the old contents.
- R4: This requirement covers an `sw_req` while `stall` is low and at least one other context is ready. At the next edge, `cur_ctx` becomes the first ready context in the order cur+1, cur+2, cur+3 (mod 4). At the same edge `fetch_pc` takes that context's saved PC and `fetch_pc_vld` is high for exactly one cycle.
- R5: Every accepted `sw_req` stores `sw_pc` as the saved PC of the context that was current. That value is what `fetch_pc` shows when the context is next resumed.
- R6: A register write and an accepted `sw_req` in the same cycle commit the write to the outgoing frame.
- R7: Read indices presented in the cycle right after a switch edge return data from the new frame.
- R8: This requirement covers an `sw_req` while `stall` is low and no other context is ready. `cur_ctx` is unchanged, `stall` is high from the next edge, and `fetch_pc_vld` stays low. While `stall` is high, `sw_req` is ignored and its `sw_pc` is not stored.
- R9: While stalled, the block resumes at the first edge where any ready flag is set. It picks the first ready context in the order cur+1, cur+2, cur+3, cur. At that edge `stall` drops and `fetch_pc_vld` pulses with that context's saved PC.
- R10: `ldr_req` rises once `LDR_WAIT` consecutive edges have passed in stall with no ready flag set. It clears at the resume edge.
- R11: When `pc_ld_en` is high, the saved PC slot of context `pc_ld_ctx` takes `pc_ld_data` at the edge. If an accepted switch saves into the same slot at the same edge, the saved `sw_pc` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_ready | input | 4 | Per-context ready flags, bit n for context n |
| sw_req | input | 1 | Switch request (cache miss or sync fault) |
| sw_pc | input | 32 | PC of the faulting instruction |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register index to write in the current frame |
| wr_data | input | 32 | Write data |
| rd_idx_a | input | 5 | Read port A index |
| rd_idx_b | input | 5 | Read port B index |
| rd_data_a | output | 32 | Read port A data, one edge after the index |
| rd_data_b | output | 32 | Read port B data, one edge after the index |
| pc_ld_en | input | 1 | Saved-PC load enable for software |
| pc_ld_ctx | input | 2 | Context whose saved PC is loaded |
| pc_ld_data | input | 32 | PC value to load |
| cur_ctx | output | 2 | Frame pointer: the current context |
| fetch_pc | output | 32 | Next fetch address after a switch or resume |
| fetch_pc_vld | output | 1 | One-cycle pulse marking a new `fetch_pc` |
| stall | output | 1 | No context ready after a switch request |
| ldr_req | output | 1 | Request for the software context loader |

## Verification
Every result of this block is due exactly one edge after the inputs that cause it. This covers read data, the new frame pointer, the fetch address and its pulse, stall entry, and resume. `ldr_req` is the exception: it is due `LDR_WAIT` edges after stall entry.

The bench drives inputs on the falling edge and runs a reference model of the requirements at that moment. It queues each expected value tagged with the rising edge at which it falls due. The monitor samples a quarter period after that edge and compares the value there.

Switch sequences are chosen so that the following are each seen at a specific cycle:

- read-before-write at the same address;
- a write in the same cycle as a switch;
- a read right after a switch;
- an ignored request during stall;
- the loader timeout.

// File: rtl/ctx_rf_pkg.sv
package ctx_rf_pkg;
  parameter int unsigned CRF_NCTX     = 4;
  parameter int unsigned CRF_NREG     = 32;
  parameter int unsigned CRF_XLEN     = 32;
  parameter int unsigned CRF_LDR_WAIT = 16;

  typedef enum logic {
    SCH_RUN   = 1'b0,
    SCH_STALL = 1'b1
  } sch_state_e;
endpackage

// File: rtl/crf_bank.sv
// Shared storage for all frames; registered, read-first ports so the
// array maps onto block RAM.
module crf_bank #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned XLEN   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

  // R2: a write is visible in the array after its edge
  assert_wr_lands_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/crf_pc_store.sv
// One saved PC per context. The switch save outranks a software load.
module crf_pc_store #(
  parameter int unsigned NCTX = 4,
  parameter int unsigned XLEN = 32,
  localparam int unsigned CTX_W = $clog2(NCTX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             save_en,
  input  logic [CTX_W-1:0] save_ctx,
  input  logic [XLEN-1:0]  save_pc,
  input  logic             ld_en,
  input  logic [CTX_W-1:0] ld_ctx,
  input  logic [XLEN-1:0]  ld_pc,
  input  logic [CTX_W-1:0] rd_ctx,
  output logic [XLEN-1:0]  rd_pc
);
  logic [XLEN-1:0] slot [NCTX];

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCTX; c++) begin
      if (rst)                                    slot[c] <= '0;
      else if (save_en && save_ctx == CTX_W'(c))  slot[c] <= save_pc;
      else if (ld_en && ld_ctx == CTX_W'(c))      slot[c] <= ld_pc;
    end
  end

  assign rd_pc = slot[rd_ctx];

  assert_save_beats_load_R11: assert property (@(posedge clk) disable iff (rst)
    (save_en && ld_en && save_ctx == ld_ctx) |=> (slot[$past(save_ctx)] == $past(save_pc)));

  assert_save_lands_R5: assert property (@(posedge clk) disable iff (rst)
    save_en |=> (slot[$past(save_ctx)] == $past(save_pc)));
endmodule

// File: rtl/crf_sched.sv
// Frame pointer, stall state, next-context search and loader timeout.
module crf_sched
  import ctx_rf_pkg::*;
#(
  parameter int unsigned NCTX     = 4,
  parameter int unsigned XLEN     = 32,
  parameter int unsigned LDR_WAIT = 16,
  localparam int unsigned CTX_W = $clog2(NCTX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_req,
  input  logic [NCTX-1:0]  ready,
  input  logic [XLEN-1:0]  slot_pc,
  output logic [CTX_W-1:0] sel_ctx,
  output logic             save_en,
  output logic [CTX_W-1:0] fp,
  output logic [XLEN-1:0]  fetch_pc,
  output logic             fetch_vld,
  output logic             stall,
  output logic             ldr_req
);
  localparam int unsigned WAIT_W = $clog2(LDR_WAIT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(LDR_WAIT - 1);

  sch_state_e        state;
  logic [WAIT_W-1:0] wait_cnt;
  logic [CTX_W-1:0]  cand, oth_sel, any_sel;
  logic              oth_hit, any_hit;

  // Scan from the highest offset down so that the nearest ready context wins.
  always_comb begin
    cand    = fp;
    oth_hit = 1'b0;
    oth_sel = fp;
    for (int k = NCTX - 1; k >= 1; k--) begin
      cand = fp + CTX_W'(k);
      if (ready[cand]) begin
        oth_hit = 1'b1;
        oth_sel = cand;
      end
    end
    any_hit = oth_hit | ready[fp];
    any_sel = oth_hit ? oth_sel : fp;
  end

  assign sel_ctx = (state == SCH_STALL) ? any_sel : oth_sel;
  assign save_en = (state == SCH_RUN) && sw_req;
  assign stall   = (state == SCH_STALL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SCH_RUN;
      fp        <= '0;
      fetch_pc  <= '0;
      fetch_vld <= 1'b0;
      wait_cnt  <= '0;
      ldr_req   <= 1'b0;
    end else begin
      fetch_vld <= 1'b0;
      unique case (state)
        SCH_RUN: begin
          if (sw_req) begin
            wait_cnt <= '0;
            ldr_req  <= 1'b0;
            if (oth_hit) begin
              fp        <= oth_sel;
              fetch_pc  <= slot_pc;
              fetch_vld <= 1'b1;
            end else begin
              state <= SCH_STALL;
            end
          end
        end
        SCH_STALL: begin
          if (any_hit) begin
            state     <= SCH_RUN;
            fp        <= any_sel;
            fetch_pc  <= slot_pc;
            fetch_vld <= 1'b1;
            wait_cnt  <= '0;
            ldr_req   <= 1'b0;
          end else begin
            if (wait_cnt != WAIT_LAST) wait_cnt <= wait_cnt + 1'b1;
            if (wait_cnt == WAIT_LAST) ldr_req <= 1'b1;
          end
        end
        default: state <= SCH_RUN;
      endcase
    end
  end

  assert_switch_moves_R4: assert property (@(posedge clk) disable iff (rst)
    (state == SCH_RUN && sw_req && oth_hit) |=> (fetch_vld && fp != $past(fp)));

  assert_hold_frame_in_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (state == SCH_STALL && !any_hit) |=> ($stable(fp) && !fetch_vld));

  assert_resume_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (state == SCH_STALL && any_hit) |=> (state == SCH_RUN && fetch_vld && !ldr_req));

  assert_loader_only_stalled_R10: assert property (@(posedge clk) disable iff (rst)
    ldr_req |-> (state == SCH_STALL));
endmodule

// File: rtl/ctx_frame_rf.sv
module ctx_frame_rf
  import ctx_rf_pkg::*;
#(
  parameter int unsigned NCTX     = CRF_NCTX,
  parameter int unsigned NREG     = CRF_NREG,
  parameter int unsigned XLEN     = CRF_XLEN,
  parameter int unsigned LDR_WAIT = CRF_LDR_WAIT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCTX-1:0]          ctx_ready,
  input  logic                     sw_req,
  input  logic [XLEN-1:0]          sw_pc,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [$clog2(NREG)-1:0]  rd_idx_a,
  input  logic [$clog2(NREG)-1:0]  rd_idx_b,
  output logic [XLEN-1:0]          rd_data_a,
  output logic [XLEN-1:0]          rd_data_b,
  input  logic                     pc_ld_en,
  input  logic [$clog2(NCTX)-1:0]  pc_ld_ctx,
  input  logic [XLEN-1:0]          pc_ld_data,
  output logic [$clog2(NCTX)-1:0]  cur_ctx,
  output logic [XLEN-1:0]          fetch_pc,
  output logic                     fetch_pc_vld,
  output logic                     stall,
  output logic                     ldr_req
);
  localparam int unsigned CTX_W  = $clog2(NCTX);
  localparam int unsigned IDX_W  = $clog2(NREG);
  localparam int unsigned ADDR_W = CTX_W + IDX_W;

  logic [CTX_W-1:0] fp, sel_ctx;
  logic             save_en;
  logic [XLEN-1:0]  slot_pc;

  crf_sched #(.NCTX(NCTX), .XLEN(XLEN), .LDR_WAIT(LDR_WAIT)) u_sched (
    .clk(clk), .rst(rst), .sw_req(sw_req), .ready(ctx_ready), .slot_pc(slot_pc),
    .sel_ctx(sel_ctx), .save_en(save_en), .fp(fp), .fetch_pc(fetch_pc),
    .fetch_vld(fetch_pc_vld), .stall(stall), .ldr_req(ldr_req)
  );

  crf_pc_store #(.NCTX(NCTX), .XLEN(XLEN)) u_pcs (
    .clk(clk), .rst(rst), .save_en(save_en), .save_ctx(fp), .save_pc(sw_pc),
    .ld_en(pc_ld_en), .ld_ctx(pc_ld_ctx), .ld_pc(pc_ld_data),
    .rd_ctx(sel_ctx), .rd_pc(slot_pc)
  );

  // The write and both reads use the pointer held before the edge.
  crf_bank #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_bank (
    .clk(clk), .rst(rst), .we(wr_en), .waddr({fp, wr_idx}), .wdata(wr_data),
    .raddr_a({fp, rd_idx_a}), .raddr_b({fp, rd_idx_b}),
    .rdata_a(rd_data_a), .rdata_b(rd_data_b)
  );

  assign cur_ctx = fp;
endmodule

// File: tb/ctx_frame_rf_tb.sv
module ctx_frame_rf_tb_top;
  localparam int LW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ctx_ready = 4'b1111;
  logic        sw_req = 1'b0;
  logic [31:0] sw_pc = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx_a = '0, rd_idx_b = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic        pc_ld_en = 1'b0;
  logic [1:0]  pc_ld_ctx = '0;
  logic [31:0] pc_ld_data = '0;
  logic [1:0]  cur_ctx;
  logic [31:0] fetch_pc;
  logic        fetch_pc_vld, stall, ldr_req;

  always #10 clk = ~clk;

  ctx_frame_rf #(.LDR_WAIT(LW)) dut_i (
    .clk(clk), .rst(rst), .ctx_ready(ctx_ready), .sw_req(sw_req), .sw_pc(sw_pc),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .pc_ld_en(pc_ld_en), .pc_ld_ctx(pc_ld_ctx), .pc_ld_data(pc_ld_data),
    .cur_ctx(cur_ctx), .fetch_pc(fetch_pc), .fetch_pc_vld(fetch_pc_vld),
    .stall(stall), .ldr_req(ldr_req)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
    int          due;
  } item_t;

  item_t q[$];
  item_t mon_it;
  int    cyc_n = 0, n_chk = 0, n_err = 0;

  // reference model state
  logic [1:0]  m_cur = '0;
  bit          m_stall = 0, m_ldr = 0;
  int          m_cnt = 0;
  logic [31:0] m_pc [4] = '{default: 32'h0};
  logic [31:0] m_rf [4][32];
  bit          ck_a = 0, ck_b = 0;

  function automatic logic [31:0] probe(int sel);
    case (sel)
      0: return rd_data_a;
      1: return rd_data_b;
      2: return 32'(cur_ctx);
      3: return fetch_pc;
      4: return 32'(fetch_pc_vld);
      5: return 32'(stall);
      default: return 32'(ldr_req);
    endcase
  endfunction

  function automatic string sname(int sel);
    case (sel)
      0: return "rd_data_a";
      1: return "rd_data_b";
      2: return "cur_ctx";
      3: return "fetch_pc";
      4: return "fetch_pc_vld";
      5: return "stall";
      default: return "ldr_req";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(int sel, logic [31:0] v, string tag);
    q.push_back('{sel, v, tag, cyc_n + 1});
  endtask

  // monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    cyc_n++;
    while (q.size() > 0 && q[0].due <= cyc_n) begin
      mon_it = q.pop_front();
      check(mon_it.tag, sname(mon_it.sel), probe(mon_it.sel), mon_it.exp);
    end
  end

  // driver: model the coming edge, queue expectations, advance one cycle
  task automatic tick(string tag);
    logic [1:0]  old_cur = m_cur;
    logic [1:0]  nxt = m_cur;
    bit          acc = !m_stall && sw_req;
    bit          hit = 0, vld = 0;
    logic [31:0] fpc = '0;
    if (ck_a) push(0, m_rf[m_cur][rd_idx_a], tag);
    if (ck_b) push(1, m_rf[m_cur][rd_idx_b], tag);
    if (wr_en) m_rf[m_cur][wr_idx] = wr_data;
    if (acc) begin
      m_pc[m_cur] = sw_pc;
      m_cnt = 0;
      m_ldr = 0;
      for (int k = 1; k < 4; k++)
        if (!hit && ctx_ready[(m_cur + k) % 4]) begin hit = 1; nxt = 2'((m_cur + k) % 4); end
      if (hit) begin vld = 1; fpc = m_pc[nxt]; end
      else m_stall = 1;
    end else if (m_stall) begin
      for (int k = 1; k <= 4; k++)
        if (!hit && ctx_ready[(m_cur + k) % 4]) begin hit = 1; nxt = 2'((m_cur + k) % 4); end
      if (hit) begin vld = 1; fpc = m_pc[nxt]; m_stall = 0; m_cnt = 0; m_ldr = 0; end
      else begin m_cnt++; if (m_cnt >= LW) m_ldr = 1; end
    end
    if (pc_ld_en && !(acc && pc_ld_ctx == old_cur)) m_pc[pc_ld_ctx] = pc_ld_data;
    m_cur = nxt;
    push(2, 32'(m_cur), tag);
    push(4, 32'(vld), tag);
    push(5, 32'(m_stall), tag);
    push(6, 32'(m_ldr), tag);
    if (vld) push(3, fpc, tag);
    @(negedge clk);
    sw_req = 0; wr_en = 0; pc_ld_en = 0; ck_a = 0; ck_b = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "cur_ctx", 32'(cur_ctx), 0);
    check("R1", "fetch_pc", fetch_pc, 0);
    check("R1", "fetch_pc_vld", 32'(fetch_pc_vld), 0);
    check("R1", "stall", 32'(stall), 0);
    check("R1", "ldr_req", 32'(ldr_req), 0);
    rst = 0;

    // R11: software seeds the saved PCs of contexts 1..3
    for (int c = 1; c < 4; c++) begin
      pc_ld_en = 1; pc_ld_ctx = 2'(c); pc_ld_data = 32'h2000 + 32'(c) * 32'h100;
      tick("R11");
    end

    // R2/R4/R6: fill each frame, then switch around the ring
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 7; i++) begin
        wr_en = 1; wr_idx = 5'(i); wr_data = 32'((c << 8) | i);
        tick("R2");
      end
      rd_idx_a = 5'd1; rd_idx_b = 5'd6; ck_a = 1; ck_b = 1;
      tick("R2");
      wr_en = 1; wr_idx = 5'd7; wr_data = 32'hC0DE0700 | 32'(c);
      sw_req = 1; sw_pc = 32'h1000 + 32'(c) * 32'h100;
      ctx_ready = 4'b1111 & ~(4'b0001 << c);
      tick("R4");
    end

    // R7: reads right after the 3->0 switch come from frame 0
    rd_idx_a = 5'd1; rd_idx_b = 5'd3; ck_a = 1; ck_b = 1;
    tick("R7");
    // R6: idx 7 written alongside the switch landed in frame 0
    rd_idx_a = 5'd7; ck_a = 1;
    tick("R6");

    // R3: read-first on a same-address write, then new value
    rd_idx_a = 5'd2; ck_a = 1; wr_en = 1; wr_idx = 5'd2; wr_data = 32'hFEED0002;
    tick("R3");
    rd_idx_a = 5'd2; ck_a = 1;
    tick("R3");

    // R5: jump to context 3, whose PC was saved at its own switch
    ctx_ready = 4'b1000; sw_req = 1; sw_pc = 32'h1400;
    tick("R5");
    // R4: skip non-ready context 0, land on 1
    ctx_ready = 4'b0110; sw_req = 1; sw_pc = 32'h1500;
    tick("R4");

    // R8: nothing ready, stall; a second request is ignored
    ctx_ready = 4'b0000; sw_req = 1; sw_pc = 32'h1600;
    tick("R8");
    sw_req = 1; sw_pc = 32'h9999;
    tick("R8");
    // R10: loader request after LW stalled edges
    for (int i = 0; i < 4; i++) tick("R10");
    // R9: only the current context becomes ready; resumes with 0x1600
    ctx_ready = 4'b0010;
    tick("R9");

    // R9: resume order cur+1.. picks context 0 over 1
    ctx_ready = 4'b0000; sw_req = 1; sw_pc = 32'h1700;
    tick("R8");
    ctx_ready = 4'b0011;
    tick("R9");

    // R11: switch save beats a same-slot software load
    ctx_ready = 4'b0100; sw_req = 1; sw_pc = 32'h1800;
    pc_ld_en = 1; pc_ld_ctx = 2'd0; pc_ld_data = 32'hBAD00000;
    tick("R11");
    ctx_ready = 4'b0001; sw_req = 1; sw_pc = 32'h1900;
    tick("R11");

    tick("R2");
    tick("R2");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule